// File: doc/BRIEF.md
# Dual-Mode Second-Order Delta-Sigma Modulator

This block turns a stream of 14-bit signed samples into a stream of 3-bit codes for a multi-level RF DAC. Modulator and DAC share one clock, so the modulator can take one sample on every clock and deliver one code on every clock. A second-order error-feedback loop shapes the quantization noise. The shaping is chosen at run time by a mode input. In highpass mode the noise is pushed away from half the clock rate, which leaves that region clean for the signal. In bandpass mode the noise is pushed away from one quarter and three quarters of the clock rate.

The loop works in 17-bit saturating arithmetic. It computes each sample's quantization error straight from the low bits of the loop value, so the recursion closes within one clock. The 3-bit code itself is resolved outside the loop by a chain of pipelined 1-bit subtract stages, one stage per output bit. Input and output each carry a valid flag. A sample that is not valid leaves the loop untouched. A change of mode clears the error history.

Top module: `ds_mod_dual`

## Requirements
- R1: While reset is high at a clock edge, out_valid is low after that edge, out_code is 4 (binary 100), and the error history is cleared.
- R2: A sample accepted at clock edge T (in_valid high) gives out_valid high after edge T+3 and low after edge T+4 unless another sample follows. out_valid repeats the in_valid pattern delayed by four edges.
- R3: The code is offset binary. With u = v + 8192, where v is the loop value, code k is produced when 2048k <= u <= 2048k+2047. If u < 0 the code is 0, and if u > 16383 the code is 7. For a first sample after reset, -8192 and -6145 give 0, -6144 gives 1, -1 gives 3, 0 gives 4 and 8191 gives 7.
- R4: Highpass mode (mode_bp = 0): v[n] = x[n] + 2e[n-1] + e[n-2]. The error is e = m - v, where m = 2048k - 7168 is the mid-step value of the chosen code k. The index n counts accepted samples.
- R5: Bandpass mode (mode_bp = 1): v[n] = x[n] + 2e[n-2] + e[n-4].
- R6: Cycles with in_valid low do not advance the error history and do not change any later code.
- R7: When mode_bp at an edge differs from its value at the previous edge, all error history is zeroed before that edge's sample (if any) is processed. After reset the previous mode counts as 0.
- R8: v saturates to the 17-bit signed range [-65536, 65535] instead of wrapping. Error and code are then computed from the saturated value.
- R9: While out_valid is low, out_code holds the last delivered code (4 after reset).
- R10: In highpass mode, an input tone at half the clock rate (x alternating +A, -A, with A = 3000) is recovered: over 1024 outputs, the sum of (-1)^n * m[n] divided by 1024 is within 8 of A.
- R11: In bandpass mode, an input tone at a quarter of the clock rate (x cycling A, 0, -A, 0) is recovered: twice the sum of c[n] * m[n] over 1024 outputs, divided by 1024, is within 16 of A, where c[n] cycles 1, 0, -1, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the DAC |
| rst | input | 1 | Synchronous active-high reset |
| mode_bp | input | 1 | 0 selects highpass noise shaping, 1 selects bandpass |
| in_valid | input | 1 | Qualifies in_sample in this cycle |
| in_sample | input | 14 | Signed input sample |
| out_valid | output | 1 | out_code carries a new code in this cycle |
| out_code | output | 3 | Offset-binary DAC code, 0 = most negative |

## Verification
The assertions assume that reset is held for at least one edge. They also assume the mode input may change on any cycle, with or without a valid sample, and they place no limit on the valid pattern. The error-bound assertion applies only when the loop value lies inside the quantizer range, so it holds for any input. The recovery and bit-exact checks run on random samples within about ±4000, which keeps the loop out of overload. Separate full-scale phases deliberately drive the loop into saturation and check that the saturated recursion still matches the expected codes.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  typedef enum logic {
    NTF_HIGHPASS = 1'b0,
    NTF_BANDPASS = 1'b1
  } ntf_sel_e;

  function automatic int mid_code(input int code_w);
    return 1 << (code_w - 1);
  endfunction

endpackage

// File: rtl/dsm_err_loop.sv
module dsm_err_loop #(
  parameter int IN_W  = 14,
  parameter int OUT_W = 3,
  parameter int ACC_W = 17
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   mode_bp,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_sample,
  output logic                   q_valid,
  output logic [IN_W-1:0]        q_level
);
  import dsm_pkg::*;

  localparam int LSB_W = IN_W - OUT_W;
  localparam int EW    = ACC_W + 1;
  localparam int SW    = ACC_W + 3;
  localparam int DEPTH = 4;

  localparam logic signed [SW-1:0] C_OFS     = SW'(2 ** (IN_W - 1));
  localparam logic signed [SW-1:0] C_HALF    = SW'(2 ** (LSB_W - 1));
  localparam logic signed [SW-1:0] C_UMAX    = SW'(2 ** IN_W - 1);
  localparam logic signed [SW-1:0] C_HIMID   = C_OFS - C_HALF;
  localparam logic signed [SW-1:0] C_LOMID   = C_HALF - C_OFS;
  localparam logic signed [SW-1:0] C_ACC_MAX = SW'(2 ** (ACC_W - 1) - 1);
  localparam logic signed [SW-1:0] C_ACC_MIN = -SW'(2 ** (ACC_W - 1));

  ntf_sel_e sel;
  ntf_sel_e sel_q;
  logic     chg;

  logic signed [EW-1:0] hist [1:DEPTH];
  logic signed [EW-1:0] heff [1:DEPTH];

  logic signed [SW-1:0] fb;
  logic signed [SW-1:0] sum_w;
  logic signed [SW-1:0] v_w;
  logic signed [SW-1:0] u_w;
  logic signed [SW-1:0] err_w;
  logic signed [EW-1:0] err;
  logic                 over_lo;
  logic                 over_hi;
  logic [IN_W-1:0]      u_clamp;

  assign sel = ntf_sel_e'(mode_bp);
  assign chg = (sel != sel_q);

  always_comb begin
    for (int k = 1; k <= DEPTH; k++) begin
      heff[k] = chg ? '0 : hist[k];
    end
  end

  // feedback taps: highpass uses lags 1,2; bandpass uses lags 2,4
  always_comb begin
    if (sel == NTF_BANDPASS) begin
      fb = (SW'(heff[2]) <<< 1) + SW'(heff[4]);
    end else begin
      fb = (SW'(heff[1]) <<< 1) + SW'(heff[2]);
    end
    sum_w = SW'(in_sample) + fb;
    if (sum_w > C_ACC_MAX) begin
      v_w = C_ACC_MAX;
    end else if (sum_w < C_ACC_MIN) begin
      v_w = C_ACC_MIN;
    end else begin
      v_w = sum_w;
    end
  end

  // error taken from the offset value's low bits, no quantizer in the loop
  always_comb begin
    u_w     = v_w + C_OFS;
    over_lo = (u_w < 0);
    over_hi = (u_w > C_UMAX);
    if (over_lo) begin
      err_w   = C_LOMID - v_w;
      u_clamp = '0;
    end else if (over_hi) begin
      err_w   = C_HIMID - v_w;
      u_clamp = '1;
    end else begin
      err_w   = C_HALF - $signed(SW'(u_w[LSB_W-1:0]));
      u_clamp = u_w[IN_W-1:0];
    end
    err = $signed(err_w[EW-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= NTF_HIGHPASS;
      q_valid <= 1'b0;
      q_level <= '0;
      for (int k = 1; k <= DEPTH; k++) begin
        hist[k] <= '0;
      end
    end else begin
      sel_q   <= sel;
      q_valid <= in_valid;
      if (in_valid) begin
        q_level <= u_clamp;
        hist[1] <= err;
        for (int k = 2; k <= DEPTH; k++) begin
          hist[k] <= heff[k-1];
        end
      end else if (chg) begin
        for (int k = 1; k <= DEPTH; k++) begin
          hist[k] <= '0;
        end
      end
    end
  end

  // R4 / R5: inside the quantizer range the error never exceeds half a step
  a_r4_err_bound: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !over_lo && !over_hi) |-> (err_w >= -C_HALF && err_w <= C_HALF));

  // R7: a mode change on an idle cycle leaves an empty history
  a_r7_mode_clear: assert property (@(posedge clk) disable iff (rst)
    (chg && !in_valid) |=> (hist[1] == '0 && hist[2] == '0 && hist[3] == '0 && hist[4] == '0));

endmodule

// File: rtl/dsm_sub_stage.sv
module dsm_sub_stage #(
  parameter int IN_W     = 14,
  parameter int OUT_W    = 3,
  parameter int IDX      = 0,
  parameter int RST_CODE = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vi,
  input  logic [IN_W-1:0]  res_i,
  input  logic [OUT_W-1:0] code_i,
  output logic             vo,
  output logic [IN_W-1:0]  res_o,
  output logic [OUT_W-1:0] code_o
);

  localparam logic [IN_W-1:0] THR = IN_W'(2 ** (IN_W - 1 - IDX));
  localparam int BITPOS = OUT_W - 1 - IDX;

  logic bit_q;
  assign bit_q = (res_i >= THR);

  always_ff @(posedge clk) begin
    if (rst) begin
      vo     <= 1'b0;
      res_o  <= '0;
      code_o <= OUT_W'(RST_CODE);
    end else begin
      vo <= vi;
      if (vi) begin
        res_o          <= bit_q ? (res_i - THR) : res_i;
        code_o         <= code_i;
        code_o[BITPOS] <= bit_q;
      end
    end
  end

  // R3: each stage leaves a residue below its own weight
  a_r3_residue_below_step: assert property (@(posedge clk) disable iff (rst)
    vo |-> (res_o < THR));

endmodule

// File: rtl/ds_mod_dual.sv
module ds_mod_dual #(
  parameter int IN_W  = 14,
  parameter int OUT_W = 3,
  parameter int ACC_W = 17
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   mode_bp,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_sample,
  output logic                   out_valid,
  output logic [OUT_W-1:0]       out_code
);

  localparam int LAT = OUT_W + 1;
  localparam int MID = dsm_pkg::mid_code(OUT_W);

  logic             v_c    [0:OUT_W];
  logic [IN_W-1:0]  res_c  [0:OUT_W];
  logic [OUT_W-1:0] code_c [0:OUT_W];

  dsm_err_loop #(
    .IN_W (IN_W),
    .OUT_W(OUT_W),
    .ACC_W(ACC_W)
  ) u_loop (
    .clk      (clk),
    .rst      (rst),
    .mode_bp  (mode_bp),
    .in_valid (in_valid),
    .in_sample(in_sample),
    .q_valid  (v_c[0]),
    .q_level  (res_c[0])
  );

  assign code_c[0] = '0;

  for (genvar i = 0; i < OUT_W; i++) begin : g_stage
    dsm_sub_stage #(
      .IN_W    (IN_W),
      .OUT_W   (OUT_W),
      .IDX     (i),
      .RST_CODE((i == OUT_W - 1) ? MID : 0)
    ) u_stage (
      .clk   (clk),
      .rst   (rst),
      .vi    (v_c[i]),
      .res_i (res_c[i]),
      .code_i(code_c[i]),
      .vo    (v_c[i+1]),
      .res_o (res_c[i+1]),
      .code_o(code_c[i+1])
    );
  end

  assign out_valid = v_c[OUT_W];
  assign out_code  = code_c[OUT_W];

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!out_valid && out_code == OUT_W'(MID)));

  // R2: fixed latency of four edges, in both directions
  a_r2_latency_hit: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##LAT out_valid);
  a_r2_latency_gap: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##LAT !out_valid);

  // R9: code holds when nothing new arrives at the last stage
  a_r9_code_hold: assert property (@(posedge clk) disable iff (rst)
    !v_c[OUT_W-1] |=> $stable(out_code));

endmodule

// File: tb/sim_ds_mod_dual.sv
module sim_ds_mod_dual;
  localparam int N_TONE = 1024;
  localparam int AMP    = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_bp = 1'b0;
  logic in_valid = 1'b0;
  logic signed [13:0] in_sample = '0;
  logic out_valid;
  logic [2:0] out_code;

  always #4 clk = ~clk;

  ds_mod_dual u0 (
    .clk      (clk),
    .rst      (rst),
    .mode_bp  (mode_bp),
    .in_valid (in_valid),
    .in_sample(in_sample),
    .out_valid(out_valid),
    .out_code (out_code)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  string tag = "R1";

  int h [1:4];
  bit m_prev;
  bit ev [0:3];
  int ec [0:3];
  int held;
  int sat_hits;

  bit acc_on = 0;
  int acc_kind = 0;
  int acc_n = 0;
  longint acc_sum = 0;

  function automatic int sat17(input int v);
    if (v > 65535) return 65535;
    if (v < -65536) return -65536;
    return v;
  endfunction

  function automatic int code_of(input int v);
    int u;
    u = v + 8192;
    if (u < 0) return 0;
    if (u > 16383) return 7;
    return u / 2048;
  endfunction

  function automatic int midv(input int k);
    return 2048 * k - 7168;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 1; k <= 4; k++) h[k] = 0;
    for (int k = 0; k < 4; k++) begin
      ev[k] = 0;
      ec[k] = 0;
    end
    m_prev = 0;
    held = 4;
  endtask

  task automatic step(input bit v, input int x, input bit m);
    int fb, raw, vs, k, e, c;
    @(negedge clk);
    check(out_valid == ev[3], tag, "out_valid", int'(out_valid), int'(ev[3]));
    check(int'(out_code) == held, ev[3] ? tag : "R9", "out_code", int'(out_code), held);
    if (acc_on && out_valid) begin
      if (acc_kind == 0) c = (acc_n % 2 == 0) ? 1 : -1;
      else c = (acc_n % 4 == 0) ? 1 : ((acc_n % 4 == 2) ? -1 : 0);
      acc_sum += longint'(c * midv(int'(out_code)));
      acc_n++;
    end
    in_valid  = v;
    in_sample = x[13:0];
    mode_bp   = m;
    @(posedge clk);
    #1;
    if (m != m_prev) for (int j = 1; j <= 4; j++) h[j] = 0;
    k = 0;
    if (v) begin
      fb  = m ? (2 * h[2] + h[4]) : (2 * h[1] + h[2]);
      raw = x + fb;
      vs  = sat17(raw);
      if (vs != raw) sat_hits++;
      k   = code_of(vs);
      e   = midv(k) - vs;
      h[4] = h[3];
      h[3] = h[2];
      h[2] = h[1];
      h[1] = e;
    end
    m_prev = m;
    for (int j = 3; j > 0; j--) begin
      ev[j] = ev[j-1];
      ec[j] = ec[j-1];
    end
    ev[0] = v;
    ec[0] = k;
    if (ev[3]) held = ec[3];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    mode_bp = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(out_code == 3'd4, "R1", "out_code after reset", int'(out_code), 4);
  endtask

  task automatic single_code(input int x, input int exp_code);
    do_reset();
    tag = "R3";
    step(1'b1, x, 1'b0);
    repeat (4) step(1'b0, 0, 1'b0);
    @(negedge clk);
    check(int'(out_code) == exp_code, "R3", "first-sample code", int'(out_code), exp_code);
  endtask

  task automatic rand_run(input string t, input int n, input int vpct,
                          input int span, input int mode_sel, input int flip_per);
    bit m;
    m = (mode_sel == 1);
    tag = t;
    for (int i = 0; i < n; i++) begin
      bit v;
      int x;
      v = ($urandom_range(99) < vpct);
      x = int'($urandom_range(2 * span)) - span;
      if (mode_sel == 2 && flip_per > 0 && $urandom_range(flip_per - 1) == 0) m = ~m;
      step(v, x, m);
    end
    repeat (5) step(1'b0, 0, m);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    sat_hits = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0, "R1", "out_valid initial", int'(out_valid), 0);
    check(out_code == 3'd4, "R1", "out_code initial", int'(out_code), 4);

    // R2: one isolated sample, valid stream checked every cycle
    tag = "R2";
    step(1'b1, -6144, 1'b0);
    repeat (5) step(1'b0, 0, 1'b0);
    @(negedge clk);
    check(int'(out_code) == 1, "R9", "held code after isolated sample", int'(out_code), 1);

    // R3: code boundaries on a fresh loop
    single_code(-8192, 0);
    single_code(-6145, 0);
    single_code(-6144, 1);
    single_code(-1, 3);
    single_code(0, 4);
    single_code(8191, 7);

    // R4 / R5 / R6 / R7 against the bench model
    do_reset();
    rand_run("R4", 1500, 100, 4000, 0, 0);
    rand_run("R5", 1500, 100, 4000, 1, 0);
    rand_run("R6", 1500, 50, 4000, 0, 0);
    rand_run("R6", 1500, 40, 4000, 1, 0);
    rand_run("R7", 2000, 75, 4000, 2, 16);

    // R8: full-scale tone at half rate drives the loop into saturation
    do_reset();
    tag = "R8";
    sat_hits = 0;
    for (int i = 0; i < 200; i++) step(1'b1, (i % 2 == 0) ? 8191 : -8192, 1'b0);
    rand_run("R8", 500, 90, 8191, 2, 32);
    check(sat_hits > 0, "R8", "saturation reached", sat_hits, 1);

    // R10: highpass tone recovery at half rate
    do_reset();
    tag = "R10";
    acc_kind = 0; acc_n = 0; acc_sum = 0; acc_on = 1;
    for (int i = 0; i < N_TONE; i++) step(1'b1, (i % 2 == 0) ? AMP : -AMP, 1'b0);
    repeat (5) step(1'b0, 0, 1'b0);
    acc_on = 0;
    check(acc_n == N_TONE, "R10", "tone output count", acc_n, N_TONE);
    check((acc_sum - longint'(AMP) * N_TONE) <= 8 * N_TONE &&
          (longint'(AMP) * N_TONE - acc_sum) <= 8 * N_TONE,
          "R10", "recovered amplitude", int'(acc_sum / N_TONE), AMP);

    // R11: bandpass tone recovery at quarter rate
    do_reset();
    tag = "R11";
    acc_kind = 1; acc_n = 0; acc_sum = 0; acc_on = 1;
    for (int i = 0; i < N_TONE; i++) begin
      int x;
      x = (i % 4 == 0) ? AMP : ((i % 4 == 2) ? -AMP : 0);
      step(1'b1, x, 1'b1);
    end
    repeat (5) step(1'b0, 0, 1'b1);
    acc_on = 0;
    check(acc_n == N_TONE, "R11", "tone output count", acc_n, N_TONE);
    check((2 * acc_sum - longint'(AMP) * N_TONE) <= 16 * N_TONE &&
          (longint'(AMP) * N_TONE - 2 * acc_sum) <= 16 * N_TONE,
          "R11", "recovered amplitude", int'(2 * acc_sum / N_TONE), AMP);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule